// File: doc/BRIEF.md
# Infrared Pulse Run-Length Encoder

This block turns the output of a consumer-infrared receiver into a stream of run-length symbols. The receiver line is resynchronised to the module clock and optionally inverted. It is then sampled on a slow tick that comes from a fixed clock divider. Each stretch of constant level becomes one byte that carries the level and the stretch length in samples. With the default divider of 64 and an 8 MHz module clock, one sample lasts 8 µs.

Short excursions, at most a programmable number of samples long, count as noise and are folded into the run around them. A run that is too long for the 7-bit length field is cut into full-length pieces. When the line rests at the space level for longer than a programmable number of samples, the block closes the packet. It emits the pending space byte, pulses a packet-end strobe and then stays silent until the next pulse. Bytes leave through a single-register valid/ready port that feeds a downstream FIFO.

Top module: `irle_top`

## Requirements
- R1: The block samples only while `glb_en` and `rx_en` are both 1 and `mode` is 2'b11, taking one sample every DIV clocks. While it is not sampling, the run state returns to idle at the space level and the block produces no byte and no packet end.
- R2: Each output byte holds the run level in bit 7 (1 = pulse, 0 = space) and the run length in samples minus one in bits 6:0.
- R3: `rx_in` passes through a two-flop synchronizer and is then XORed with `invert`. With `invert` = 1 a low raw line is a pulse.
- R4: The noise threshold is `sample_cfg[7:2]`. A level excursion of at most that many samples is merged into the surrounding run and produces no byte, and one that lasts longer starts a new run. A threshold of 0 accepts single-sample runs.
- R5: A run longer than 128 samples produces a byte with length field 0x7F for each completed 128 samples, at the same level, and counting carries on with the remainder.
- R6: The idle threshold is `sample_cfg[15:8]`. When a space run reaches the threshold plus one samples, the block emits that space byte and pulses `pkt_end` for exactly one cycle. If the port was free, the pulse falls in the cycle in which that byte first shows on the port.
- R7: After reset and after a packet end, the block emits nothing until a pulse run is accepted by the noise filter, and no byte is produced for the idle space before it.
- R8: A presented byte stays on `out_data` with `out_valid` high until `out_ready` is seen. A byte produced while the port holds an unaccepted byte is dropped.
- R9: After reset, `out_valid` and `pkt_end` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_in | input | 1 | Raw receiver line, asynchronous |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| mode | input | 2 | Operating mode, 2'b11 selects run-length sampling |
| invert | input | 1 | Invert the synchronised line |
| sample_cfg | input | 16 | [7:2] noise threshold, [15:8] idle threshold, [1:0] unused |
| out_ready | input | 1 | Downstream can take a byte |
| out_valid | output | 1 | `out_data` holds a byte |
| out_data | output | 8 | Level in bit 7, length minus one in bits 6:0 |
| pkt_end | output | 1 | One-cycle end-of-packet strobe |

## Verification
Closing the last space run and raising the packet-end strobe fall in the same cycle. Every scenario that ends in a long space provokes this. A monitor checks that each `pkt_end` pulse seen while the port is free comes with a valid space-level byte on `out_data`. The run split and a merged glitch can also fall on the same sample. The 300-sample run and the glitch scenario judge the result by the exact sequence of bytes received.

// File: rtl/irle_pkg.sv
// Package: shared symbol type and widths for the IR run-length encoder.
// Assumes the output symbol is always one byte: level bit plus 7-bit length.
package irle_pkg;
    localparam int IRLE_LEN_W = 7;
    localparam int IRLE_RUN_MAX = 1 << IRLE_LEN_W;

    typedef struct packed {
        logic                  lvl;
        logic [IRLE_LEN_W-1:0] len_m1;
    } irle_sym_t;
endpackage

// File: rtl/irle_tick.sv
// Sample tick divider: one-cycle tick every DIV clocks while enabled.
// Assumes DIV >= 2; disabling clears the phase so sampling restarts cleanly.
module irle_tick #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CNT_W-1:0] cnt;

    // Divide the module clock down to the sample rate.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CNT_W'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + CNT_W'(1);
            tick <= 1'b0;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
endmodule

// File: rtl/irle_sync.sv
// Input conditioner: multi-flop synchronizer followed by polarity inversion.
// Assumes STAGES >= 2; invert is quasi-static and used without synchronizing.
module irle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    input  logic invert,
    output logic lvl
);
    logic [STAGES-1:0] sh;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], rx_in};
    end

    // Apply the polarity control after synchronizing.
    always_comb lvl = sh[STAGES-1] ^ invert;
endmodule

// File: rtl/irle_runner.sv
// Run counter: glitch filter, run length counting, long-run splitting and
// idle (packet end) detection, all advanced once per sample tick.
// Assumes noise and idle thresholds change only while the line is idle.
module irle_runner
    import irle_pkg::*;
#(
    parameter int NOISE_W = 6,
    parameter int IDLE_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               tick,
    input  logic               lvl,
    input  logic [NOISE_W-1:0] noise_thr,
    input  logic [IDLE_W-1:0]  idle_thr,
    output logic               emit,
    output irle_sym_t          sym,
    output logic               pkt
);
    localparam int CAND_W = NOISE_W + 1;
    localparam int TOT_W  = ((IRLE_LEN_W > CAND_W) ? IRLE_LEN_W : CAND_W) + 2;
    localparam int ICNT_W = ((IDLE_W > CAND_W) ? IDLE_W : CAND_W) + 2;

    logic              cur_lvl, idle_st;
    logic [TOT_W-1:0]  total;
    logic [CAND_W-1:0] cand;
    logic [ICNT_W-1:0] icnt;

    logic              nx_lvl, nx_idle, nx_emit, nx_pkt;
    logic [TOT_W-1:0]  nx_total;
    logic [CAND_W-1:0] nx_cand;
    logic [ICNT_W-1:0] nx_icnt;
    irle_sym_t         nx_sym;

    logic [CAND_W-1:0] cand_inc;
    logic [TOT_W-1:0]  tot_inc, old_len;
    logic [ICNT_W-1:0] icnt_new;

    // Derived counts used by the next-state logic.
    always_comb begin
        cand_inc = cand + CAND_W'(1);
        tot_inc  = total + TOT_W'(1);
        old_len  = total - TOT_W'(cand);
        icnt_new = icnt + ICNT_W'(cand) + ICNT_W'(1);
    end

    // Next-state logic for one sample.
    always_comb begin
        nx_lvl   = cur_lvl;
        nx_idle  = idle_st;
        nx_total = total;
        nx_cand  = cand;
        nx_icnt  = icnt;
        nx_emit  = 1'b0;
        nx_pkt   = 1'b0;
        nx_sym   = '0;
        if (tick) begin
            if (lvl != cur_lvl) begin
                if (!idle_st) nx_total = tot_inc;
                if (cand_inc > {1'b0, noise_thr}) begin
                    if (!idle_st) begin
                        nx_emit       = 1'b1;
                        nx_sym.lvl    = cur_lvl;
                        nx_sym.len_m1 = IRLE_LEN_W'(old_len - TOT_W'(1));
                    end
                    nx_lvl   = lvl;
                    nx_idle  = 1'b0;
                    nx_total = TOT_W'(cand_inc);
                    nx_cand  = '0;
                    nx_icnt  = lvl ? '0 : ICNT_W'(cand_inc);
                end else begin
                    nx_cand = cand_inc;
                end
            end else begin
                nx_cand = '0;
                if (!idle_st) begin
                    if (!cur_lvl && (icnt_new > ICNT_W'(idle_thr))) begin
                        nx_emit       = 1'b1;
                        nx_pkt        = 1'b1;
                        nx_sym.lvl    = 1'b0;
                        nx_sym.len_m1 = (tot_inc > TOT_W'(IRLE_RUN_MAX)) ?
                                        {IRLE_LEN_W{1'b1}} :
                                        IRLE_LEN_W'(tot_inc - TOT_W'(1));
                        nx_idle       = 1'b1;
                        nx_total      = '0;
                        nx_icnt       = '0;
                    end else if (tot_inc > TOT_W'(IRLE_RUN_MAX)) begin
                        nx_emit       = 1'b1;
                        nx_sym.lvl    = cur_lvl;
                        nx_sym.len_m1 = {IRLE_LEN_W{1'b1}};
                        nx_total      = tot_inc - TOT_W'(IRLE_RUN_MAX);
                        nx_icnt       = cur_lvl ? '0 : icnt_new;
                    end else begin
                        nx_total = tot_inc;
                        nx_icnt  = cur_lvl ? '0 : icnt_new;
                    end
                end
            end
        end
    end

    // Commit the run state; disable returns to idle space.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cur_lvl <= 1'b0;
            idle_st <= 1'b1;
            total   <= '0;
            cand    <= '0;
            icnt    <= '0;
            emit    <= 1'b0;
            pkt     <= 1'b0;
            sym     <= '0;
        end else begin
            cur_lvl <= nx_lvl;
            idle_st <= nx_idle;
            total   <= nx_total;
            cand    <= nx_cand;
            icnt    <= nx_icnt;
            emit    <= nx_emit;
            pkt     <= nx_pkt;
            sym     <= nx_sym;
        end
    end

    AST_EMIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> $past(tick)); // R1
    AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !emit && !pkt); // R1
    AST_PKT_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt |-> emit && !sym.lvl); // R6
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(idle_st) |-> !emit); // R7
endmodule

// File: rtl/irle_out.sv
// Output stage: one-byte valid/ready holding register and packet-end strobe.
// Assumes the consumer samples out_data on a cycle with out_valid and out_ready.
module irle_out
    import irle_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      emit,
    input  irle_sym_t sym,
    input  logic      pkt_in,
    input  logic      out_ready,
    output logic      out_valid,
    output logic [7:0] out_data,
    output logic      pkt_end
);
    logic can_load;

    // The register may take a new byte when empty or being drained.
    always_comb can_load = !out_valid || out_ready;

    // Hold or replace the presented byte; drop when full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (emit && can_load) begin
            out_valid <= 1'b1;
            out_data  <= sym;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Align the packet-end strobe with the byte it closes.
    always_ff @(posedge clk) begin
        if (!rst_n) pkt_end <= 1'b0;
        else        pkt_end <= pkt_in;
    end

    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
    AST_PKT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> !pkt_end); // R6
endmodule

// File: rtl/irle_top.sv
// Top: IR run-length encoder. Synchronizes and optionally inverts the line,
// samples it every DIV clocks, filters glitches, emits level/length bytes and
// flags packet end. Assumes configuration is changed only while idle.
module irle_top #(
    parameter int DIV         = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_in,
    input  logic        glb_en,
    input  logic        rx_en,
    input  logic [1:0]  mode,
    input  logic        invert,
    input  logic [15:0] sample_cfg,
    input  logic        out_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        pkt_end
);
    import irle_pkg::*;

    localparam logic [1:0] MODE_RUN = 2'b11;

    logic      run_en, tick, lvl, emit, pkt;
    irle_sym_t sym;
    logic      cfg_unused;

    // Sampling is allowed only in run-length mode with both enables set.
    always_comb run_en = glb_en && rx_en && (mode == MODE_RUN);
    always_comb cfg_unused = ^sample_cfg[1:0];

    irle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .invert(invert), .lvl(lvl)
    );

    irle_tick #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(run_en), .tick(tick)
    );

    irle_runner #(.NOISE_W(6), .IDLE_W(8)) u_run (
        .clk(clk), .rst_n(rst_n), .en(run_en), .tick(tick), .lvl(lvl),
        .noise_thr(sample_cfg[7:2]), .idle_thr(sample_cfg[15:8]),
        .emit(emit), .sym(sym), .pkt(pkt)
    );

    irle_out u_out (
        .clk(clk), .rst_n(rst_n), .emit(emit), .sym(sym), .pkt_in(pkt),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .pkt_end(pkt_end)
    );
endmodule

// File: tb/irle_top_test.sv
`timescale 1ns/1ps
module irle_top_test;
    localparam int DIV = 8;
    // {level, samples, expected byte}
    localparam logic [16:0] VECS [7] = '{
        {1'b1, 8'd9,  8'h88}, {1'b0, 8'd5,  8'h04}, {1'b1, 8'd3,  8'h82},
        {1'b0, 8'd17, 8'h10}, {1'b1, 8'd2,  8'h81}, {1'b0, 8'd12, 8'h0B},
        {1'b1, 8'd40, 8'hA7}
    };

    logic clk = 1'b0, rst_n = 1'b0, rx_in = 1'b0, glb_en = 1'b0, rx_en = 1'b0;
    logic [1:0] mode = 2'b00;
    logic invert = 1'b0, out_ready = 1'b1;
    logic [15:0] sample_cfg = 16'h0;
    logic out_valid, pkt_end;
    logic [7:0] out_data;
    logic inv_b = 1'b0;

    int n_chk = 0, n_fail = 0, ncap = 0, npkt = 0, base = 0, pbase = 0;
    logic [7:0] cap [0:255];

    always #4 clk = ~clk;

    irle_top #(.DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .glb_en(glb_en), .rx_en(rx_en),
        .mode(mode), .invert(invert), .sample_cfg(sample_cfg),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .pkt_end(pkt_end)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Hold the logical level for n samples (raw line follows inv_b).
    task automatic run(input logic l, input int n);
        rx_in = l ^ inv_b;
        repeat (n * DIV) @(posedge clk);
        #1;
    endtask

    task automatic set_thr(input int noise, input int idle);
        sample_cfg = {8'(idle), 6'(noise), 2'b00};
    endtask

    task automatic mark();
        base = ncap;
        pbase = npkt;
    endtask

    // Monitor: capture handshakes and check the packet-end coincidence (R6).
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready && ncap < 256) begin
                cap[ncap] = out_data;
                ncap++;
            end
            if (pkt_end) begin
                npkt++;
                if (out_ready) chk("R6 pkt_end with space byte", {15'h0, out_valid && !out_data[7]}, 16'h1);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R9 out_valid after reset", {15'h0, out_valid}, 16'h0);
        chk("R9 pkt_end after reset", {15'h0, pkt_end}, 16'h0);
        @(posedge clk); #1;

        glb_en = 1'b1; rx_en = 1'b1; mode = 2'b11;
        set_thr(1, 20);
        run(1'b0, 5);

        // Table walk: R2 byte format over alternating runs.
        mark();
        for (int i = 0; i < 7; i++) run(VECS[i][16], int'(VECS[i][15:8]));
        run(1'b0, 40);
        for (int i = 0; i < 7; i++) chk("R2 table byte", {8'h0, cap[base+i]}, {8'h0, VECS[i][7:0]});
        chk("R6 final space byte", {8'h0, cap[base+7]}, 16'h0014);
        chk("R6 one packet end", 16'(npkt - pbase), 16'd1);
        // R7: long idle stays silent after packet end
        mark();
        run(1'b0, 150);
        chk("R7 no bytes after packet end", 16'(ncap - base), 16'd0);

        // R4: glitch of 2 samples merged with threshold 2
        set_thr(2, 20);
        mark();
        run(1'b1, 10); run(1'b0, 2); run(1'b1, 10); run(1'b0, 30);
        chk("R4 glitch merged count", 16'(ncap - base), 16'd2);
        chk("R4 merged pulse byte", {8'h0, cap[base]}, 16'h0095);
        chk("R4 space after merge", {8'h0, cap[base+1]}, 16'h0014);
        // R4: 3-sample excursion above threshold 2 is a run
        mark();
        run(1'b1, 4); run(1'b0, 3); run(1'b1, 4); run(1'b0, 30);
        chk("R4 boundary count", 16'(ncap - base), 16'd4);
        chk("R4 boundary pulse", {8'h0, cap[base]}, 16'h0083);
        chk("R4 boundary space", {8'h0, cap[base+1]}, 16'h0002);
        chk("R4 boundary pulse2", {8'h0, cap[base+2]}, 16'h0083);
        // R4: threshold 0 keeps a single-sample pulse
        set_thr(0, 20);
        mark();
        run(1'b1, 1); run(1'b0, 30);
        chk("R4 single sample pulse", {8'h0, cap[base]}, 16'h0080);
        chk("R4 single sample count", 16'(ncap - base), 16'd2);

        // R5: long runs split into 0x7F pieces
        set_thr(1, 20);
        mark();
        run(1'b1, 300); run(1'b0, 30);
        chk("R5 split count", 16'(ncap - base), 16'd4);
        chk("R5 split piece 1", {8'h0, cap[base]}, 16'h00FF);
        chk("R5 split piece 2", {8'h0, cap[base+1]}, 16'h00FF);
        chk("R5 split remainder", {8'h0, cap[base+2]}, 16'h00AB);
        mark();
        run(1'b1, 128); run(1'b0, 30);
        chk("R5 exact 128 byte", {8'h0, cap[base]}, 16'h00FF);
        chk("R5 exact 128 count", 16'(ncap - base), 16'd2);

        // R3: inverted polarity, raw low is a pulse
        inv_b = 1'b1; invert = 1'b1; rx_in = 1'b1;
        run(1'b0, 10);
        mark();
        run(1'b1, 6); run(1'b0, 30);
        chk("R3 inverted pulse byte", {8'h0, cap[base]}, 16'h0085);
        chk("R3 inverted count", 16'(ncap - base), 16'd2);
        inv_b = 1'b0; invert = 1'b0; rx_in = 1'b0;
        run(1'b0, 10);

        // R8: back-pressure holds the first byte and drops the rest
        out_ready = 1'b0;
        mark();
        run(1'b1, 5); run(1'b0, 5); run(1'b1, 5); run(1'b0, 30);
        @(negedge clk);
        chk("R8 held valid", {15'h0, out_valid}, 16'h1);
        chk("R8 held byte", {8'h0, out_data}, 16'h0084);
        chk("R6 pkt_end while stalled", 16'(npkt - pbase), 16'd1);
        @(posedge clk); #1 out_ready = 1'b1;
        repeat (4) @(posedge clk); #1;
        chk("R8 only held byte delivered", 16'(ncap - base), 16'd1);
        chk("R8 delivered value", {8'h0, cap[base]}, 16'h0084);

        // R1: wrong mode means no sampling at all
        mode = 2'b10;
        mark();
        run(1'b1, 10); run(1'b0, 10); run(1'b1, 10); run(1'b0, 30);
        chk("R1 no bytes when mode off", 16'(ncap - base), 16'd0);
        chk("R1 no pkt_end when mode off", 16'(npkt - pbase), 16'd0);
        mode = 2'b11;
        mark();
        run(1'b0, 5); run(1'b1, 7); run(1'b0, 30);
        chk("R1 resumed pulse byte", {8'h0, cap[base]}, 16'h0086);
        chk("R1 resumed count", 16'(ncap - base), 16'd2);

        summary();
    end
endmodule